// File: doc/BRIEF.md
# Dual-Side Address Window Translator

This block converts requester addresses into target addresses for two independent requesters: a processor-side port and a DMA-side port coming from the PCI bus. Each side owns four windows. A window consists of a 64-bit base, a 64-bit mask and a 64-bit remap word. An address that falls inside an enabled window is rebased onto the remap address. The low bit of the remap word selects the target. The response reports the translated address, the target select and whether any window matched.

A flat configuration port programs every window register and reads it back. The port has a single-cycle write strobe and a combinational read path over a 384-byte space. Out of reset, two processor-side windows are already live, so boot code can reach low DRAM and the low PCI memory region before any register is written. Each translation request is answered one clock later. The answer uses the window contents that were present on the clock edge that accepted the request.

Top module: `awt_top`

## Requirements
- R1: After reset, processor window 0 sends [0, 256 MiB) to DRAM (select 0) with the address unchanged. Processor window 1 sends [256 MiB, 512 MiB) to the PCI/IO target (select 1) with the address unchanged. No DMA-side window is enabled.
- R2: Configuration byte offsets decode as follows. The processor-side base registers are at 0x00+8·w, its masks at 0x20+8·w and its remap words at 0x40+8·w. The DMA side uses the same layout shifted by 0x60. Here w is the window number 0..3. A write stores all 64 bits, and a read at the same offset returns them.
- R3: A read from any offset at or above 0xC0 inside the 384-byte space returns zero. A write to such an offset changes no register and no translation.
- R4: An address matches a window when the address and the base agree in every bit position where the mask holds a one.
- R5: On a match, the translated address takes the remap word, with its bit 0 cleared, in the positions where the mask is one. It takes the request address in the positions where the mask is zero.
- R6: The target select equals bit 0 of the winning window's remap word. Value 0 means DRAM. Value 1 means PCI on the processor side and local I/O on the DMA side.
- R7: When several windows match, the lowest-numbered window decides the response.
- R8: When no window matches, the hit flag is 0, the select is 0 and the address is returned unchanged.
- R9: A window that is not enabled at reset never matches, even after its base and mask are written. It becomes enabled on the first write to its remap word.
- R10: Each accepted request (valid high at a clock edge) produces a response with valid high on the next edge. The response uses the register values from before any configuration write on that same edge. A write becomes visible to requests sampled on the following edge.
- R11: The two sides translate independently. Windows programmed for one side have no effect on the other side's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 9 | Configuration byte offset; bits 2:0 ignored |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Read data for cfg_addr, combinational |
| cpu_req_valid | input | 1 | Processor-side request valid |
| cpu_req_addr | input | 64 | Processor-side request address |
| cpu_rsp_valid | output | 1 | Processor-side response valid |
| cpu_rsp_addr | output | 64 | Processor-side translated address |
| cpu_rsp_dst | output | 1 | Processor-side target select (0 DRAM, 1 PCI) |
| cpu_rsp_hit | output | 1 | Processor-side window match |
| dma_req_valid | input | 1 | DMA-side request valid |
| dma_req_addr | input | 64 | DMA-side request address |
| dma_rsp_valid | output | 1 | DMA-side response valid |
| dma_rsp_addr | output | 64 | DMA-side translated address |
| dma_rsp_dst | output | 1 | DMA-side target select (0 DRAM, 1 local I/O) |
| dma_rsp_hit | output | 1 | DMA-side window match |

## Verification
The properties assume that the requester keeps its address stable during a request cycle, so the response can be compared against the sampled request address one cycle later. They also assume that software programs masks as a run of high ones, which makes every window a power of two in size. The stimulus writes only power-of-two masks and holds request inputs between falling edges. It includes a configuration write and a request on the same edge, which exercises the old-value rule in R10. The windows it programs overlap on purpose, so that the lowest-number rule in R7 decides real conflicts.

// File: rtl/awt_pkg.sv
package awt_pkg;
  localparam int unsigned ADDR_W = 64;
  localparam int unsigned NSIDE  = 2;
  typedef logic [ADDR_W-1:0] addr_t;

  // Bit 0 of a remap word carries the target code.
  localparam addr_t DST_FIELD = addr_t'(1);

  // A window matches when the address agrees with the base on every masked bit.
  function automatic logic win_match(input addr_t a, input addr_t base, input addr_t mask);
    return ((a ^ base) & mask) == '0;
  endfunction

  // Masked bits come from the remap address, unmasked bits from the request.
  function automatic addr_t win_xlate(input addr_t a, input addr_t mask, input addr_t remap);
    return ((remap & ~DST_FIELD) & mask) | (a & ~mask);
  endfunction
endpackage

// File: rtl/awt_cfg.sv
module awt_cfg
  import awt_pkg::*;
#(
  parameter int unsigned NWIN      = 4,
  parameter int unsigned CFG_AW    = 9,
  parameter addr_t       BOOT_SPAN = addr_t'(64'h1000_0000)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr,
  input  logic [CFG_AW-1:0]                 addr,
  input  addr_t                             wdata,
  output addr_t                             rdata,
  output addr_t [NSIDE-1:0][NWIN-1:0]       base_q,
  output addr_t [NSIDE-1:0][NWIN-1:0]       mask_q,
  output addr_t [NSIDE-1:0][NWIN-1:0]       remap_q,
  output logic  [NSIDE-1:0][NWIN-1:0]       en_q
);
  localparam int unsigned OFFW      = CFG_AW - 3;
  localparam int unsigned SIDE_WDS  = 3 * NWIN;
  localparam addr_t       BOOT_MASK = ~(BOOT_SPAN - addr_t'(1));

  logic [OFFW-1:0] word;
  assign word = addr[CFG_AW-1:3];

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    for (genvar w = 0; w < NWIN; w++) begin : g_win
      localparam logic [OFFW-1:0] A_BASE  = OFFW'(s*SIDE_WDS + w);
      localparam logic [OFFW-1:0] A_MASK  = OFFW'(s*SIDE_WDS + NWIN + w);
      localparam logic [OFFW-1:0] A_REMAP = OFFW'(s*SIDE_WDS + 2*NWIN + w);
      localparam bit    IS_BOOT0 = (s == 0) && (w == 0);
      localparam bit    IS_BOOT1 = (s == 0) && (w == 1);
      localparam addr_t RST_BASE  = IS_BOOT0 ? addr_t'(0) : (IS_BOOT1 ? BOOT_SPAN : '1);
      localparam addr_t RST_MASK  = (IS_BOOT0 || IS_BOOT1) ? BOOT_MASK : '1;
      localparam addr_t RST_REMAP = IS_BOOT1 ? (BOOT_SPAN | DST_FIELD) : addr_t'(0);
      localparam bit    RST_EN    = IS_BOOT0 || IS_BOOT1;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          base_q[s][w]  <= RST_BASE;
          mask_q[s][w]  <= RST_MASK;
          remap_q[s][w] <= RST_REMAP;
          en_q[s][w]    <= RST_EN;
        end else if (wr) begin
          if (word == A_BASE)  base_q[s][w] <= wdata;
          if (word == A_MASK)  mask_q[s][w] <= wdata;
          if (word == A_REMAP) begin
            remap_q[s][w] <= wdata;
            en_q[s][w]    <= 1'b1;
          end
        end
      end
    end
  end

  // Read mux: offsets outside the implemented words fall through to zero.
  always_comb begin
    rdata = '0;
    for (int s = 0; s < NSIDE; s++) begin
      for (int w = 0; w < NWIN; w++) begin
        if (word == OFFW'(s*SIDE_WDS + w))          rdata = base_q[s][w];
        if (word == OFFW'(s*SIDE_WDS + NWIN + w))   rdata = mask_q[s][w];
        if (word == OFFW'(s*SIDE_WDS + 2*NWIN + w)) rdata = remap_q[s][w];
      end
    end
  end
endmodule

// File: rtl/awt_side.sv
module awt_side
  import awt_pkg::*;
#(
  parameter int unsigned NWIN = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  addr_t                req_addr,
  input  addr_t [NWIN-1:0]     base,
  input  addr_t [NWIN-1:0]     mask,
  input  addr_t [NWIN-1:0]     remap,
  input  logic  [NWIN-1:0]     en,
  output logic  [NWIN-1:0]     sel,
  output logic                 rsp_valid,
  output addr_t                rsp_addr,
  output logic                 rsp_dst,
  output logic                 rsp_hit
);
  logic [NWIN-1:0] match;
  addr_t           xa;
  logic            xdst;

  for (genvar w = 0; w < NWIN; w++) begin : g_match
    assign match[w] = en[w] && win_match(req_addr, base[w], mask[w]);
  end

  // Lowest-numbered matching window wins.
  always_comb begin
    logic found;
    sel   = '0;
    found = 1'b0;
    for (int w = 0; w < NWIN; w++) begin
      if (match[w] && !found) begin
        sel[w] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    xa   = req_addr;
    xdst = 1'b0;
    for (int w = 0; w < NWIN; w++) begin
      if (sel[w]) begin
        xa   = win_xlate(req_addr, mask[w], remap[w]);
        xdst = remap[w][0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_dst   <= 1'b0;
      rsp_hit   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_addr <= xa;
        rsp_dst  <= xdst;
        rsp_hit  <= |sel;
      end
    end
  end
endmodule

// File: rtl/awt_top.sv
module awt_top
  import awt_pkg::*;
#(
  parameter int unsigned NWIN      = 4,
  parameter int unsigned CFG_BYTES = 384,
  parameter addr_t       BOOT_SPAN = addr_t'(64'h1000_0000)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [8:0]    cfg_addr,
  input  logic [63:0]   cfg_wdata,
  output logic [63:0]   cfg_rdata,
  input  logic          cpu_req_valid,
  input  logic [63:0]   cpu_req_addr,
  output logic          cpu_rsp_valid,
  output logic [63:0]   cpu_rsp_addr,
  output logic          cpu_rsp_dst,
  output logic          cpu_rsp_hit,
  input  logic          dma_req_valid,
  input  logic [63:0]   dma_req_addr,
  output logic          dma_rsp_valid,
  output logic [63:0]   dma_rsp_addr,
  output logic          dma_rsp_dst,
  output logic          dma_rsp_hit
);
  localparam int unsigned CFG_AW = $clog2(CFG_BYTES);

  addr_t [NSIDE-1:0][NWIN-1:0] w_base, w_mask, w_remap;
  logic  [NSIDE-1:0][NWIN-1:0] s_vld;
  logic  [NSIDE-1:0][NWIN-1:0] s_sel;
  logic  [NSIDE-1:0]           s_req_v, s_rsp_v, s_rsp_d, s_rsp_h;
  addr_t [NSIDE-1:0]           s_req_a, s_rsp_a;

  assign s_req_v = {dma_req_valid, cpu_req_valid};
  assign s_req_a = {dma_req_addr, cpu_req_addr};

  awt_cfg #(.NWIN(NWIN), .CFG_AW(CFG_AW), .BOOT_SPAN(BOOT_SPAN)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (cfg_wr),
    .addr    (cfg_addr[CFG_AW-1:0]),
    .wdata   (cfg_wdata),
    .rdata   (cfg_rdata),
    .base_q  (w_base),
    .mask_q  (w_mask),
    .remap_q (w_remap),
    .en_q    (s_vld)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    awt_side #(.NWIN(NWIN)) u_side (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (s_req_v[s]),
      .req_addr  (s_req_a[s]),
      .base      (w_base[s]),
      .mask      (w_mask[s]),
      .remap     (w_remap[s]),
      .en        (s_vld[s]),
      .sel       (s_sel[s]),
      .rsp_valid (s_rsp_v[s]),
      .rsp_addr  (s_rsp_a[s]),
      .rsp_dst   (s_rsp_d[s]),
      .rsp_hit   (s_rsp_h[s])
    );
  end

  assign cpu_rsp_valid = s_rsp_v[0];
  assign cpu_rsp_addr  = s_rsp_a[0];
  assign cpu_rsp_dst   = s_rsp_d[0];
  assign cpu_rsp_hit   = s_rsp_h[0];
  assign dma_rsp_valid = s_rsp_v[1];
  assign dma_rsp_addr  = s_rsp_a[1];
  assign dma_rsp_dst   = s_rsp_d[1];
  assign dma_rsp_hit   = s_rsp_h[1];
endmodule

// File: rtl/awt_chk.sv
module awt_chk
  import awt_pkg::*;
#(
  parameter int unsigned NWIN   = 4,
  parameter int unsigned CFG_AW = 9
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [8:0]                  cfg_addr,
  input logic [63:0]                 cfg_rdata,
  input logic [NSIDE-1:0]            req_v,
  input addr_t [NSIDE-1:0]           req_a,
  input logic [NSIDE-1:0]            rsp_v,
  input addr_t [NSIDE-1:0]           rsp_a,
  input logic [NSIDE-1:0]            rsp_h,
  input logic [NSIDE-1:0]            rsp_d,
  input logic [NSIDE-1:0][NWIN-1:0]  sel,
  input logic [NSIDE-1:0][NWIN-1:0]  vld
);
  // R3
  hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr[CFG_AW-1:3] >= (CFG_AW-3)'(6*NWIN)) |-> cfg_rdata == '0);

  for (genvar s = 0; s < NSIDE; s++) begin : g_s
    // R10
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_v[s] |=> rsp_v[s]);
    // R10
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_v[s] |=> !rsp_v[s]);
    // R8
    miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_v[s] |=> (rsp_h[s] || rsp_a[s] == $past(req_a[s])));
    // R8
    miss_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_v[s] && !rsp_h[s]) |-> !rsp_d[s]);
    // R7
    one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel[s]));
    for (genvar w = 0; w < NWIN; w++) begin : g_w
      // R9
      closed_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld[s][w] |-> !sel[s][w]);
    end
  end
endmodule

bind awt_top awt_chk #(.NWIN(NWIN), .CFG_AW(CFG_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata),
  .req_v     (s_req_v),
  .req_a     (s_req_a),
  .rsp_v     (s_rsp_v),
  .rsp_a     (s_rsp_a),
  .rsp_h     (s_rsp_h),
  .rsp_d     (s_rsp_d),
  .sel       (s_sel),
  .vld       (s_vld)
);

// File: tb/sim_awt_top.sv
module sim_awt_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [8:0]  cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        cpu_req_valid = 1'b0;
  logic [63:0] cpu_req_addr = '0;
  logic        cpu_rsp_valid, cpu_rsp_dst, cpu_rsp_hit;
  logic [63:0] cpu_rsp_addr;
  logic        dma_req_valid = 1'b0;
  logic [63:0] dma_req_addr = '0;
  logic        dma_rsp_valid, dma_rsp_dst, dma_rsp_hit;
  logic [63:0] dma_rsp_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase = "R10";

  always #4 clk = ~clk;

  awt_top u0 (.*);

  // Behavioural reference model
  logic [63:0] m_base [2][4];
  logic [63:0] m_mask [2][4];
  logic [63:0] m_map  [2][4];
  bit          m_on   [2][4];
  bit          e_v [2];
  bit          e_h [2];
  bit          e_d [2];
  logic [63:0] e_a [2];

  task automatic model_reset();
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 4; w++) begin
        m_base[s][w] = '1; m_mask[s][w] = '1; m_map[s][w] = '0; m_on[s][w] = 0;
      end
    m_base[0][0] = 64'h0;         m_mask[0][0] = 64'hFFFF_FFFF_F000_0000; m_on[0][0] = 1;
    m_base[0][1] = 64'h1000_0000; m_mask[0][1] = 64'hFFFF_FFFF_F000_0000; m_on[0][1] = 1;
    m_map[0][1]  = 64'h1000_0001;
    for (int s = 0; s < 2; s++) begin e_v[s] = 0; e_h[s] = 0; e_d[s] = 0; e_a[s] = '0; end
  endtask

  function automatic logic [63:0] model_read(input logic [8:0] off);
    int o, s, k, w;
    o = int'(off) & ~7;
    if (o >= 'hC0) return '0;
    s = o / 'h60; k = (o % 'h60) / 'h20; w = (o % 'h20) / 8;
    if (k == 0) return m_base[s][w];
    if (k == 1) return m_mask[s][w];
    return m_map[s][w];
  endfunction

  task automatic model_step();
    logic [63:0] a;
    bit          v;
    int o, s, k, w;
    for (int sd = 0; sd < 2; sd++) begin
      v = (sd == 0) ? cpu_req_valid : dma_req_valid;
      a = (sd == 0) ? cpu_req_addr  : dma_req_addr;
      e_v[sd] = v;
      if (v) begin
        e_h[sd] = 0; e_d[sd] = 0; e_a[sd] = a;
        for (int w2 = 0; w2 < 4; w2++) begin
          if (m_on[sd][w2] && ((a & m_mask[sd][w2]) == (m_base[sd][w2] & m_mask[sd][w2]))) begin
            e_h[sd] = 1;
            e_d[sd] = m_map[sd][w2][0];
            e_a[sd] = ((m_map[sd][w2] & ~64'h1) & m_mask[sd][w2]) + (a & ~m_mask[sd][w2]);
            break;
          end
        end
      end
    end
    if (cfg_wr) begin
      o = int'(cfg_addr) & ~7;
      if (o < 'hC0) begin
        s = o / 'h60; k = (o % 'h60) / 'h20; w = (o % 'h20) / 8;
        if (k == 0) m_base[s][w] = cfg_wdata;
        else if (k == 1) m_mask[s][w] = cfg_wdata;
        else begin m_map[s][w] = cfg_wdata; m_on[s][w] = 1; end
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Compare every clock against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({phase, " cpu valid"}, 64'(cpu_rsp_valid), 64'(e_v[0]));
      check({phase, " dma valid"}, 64'(dma_rsp_valid), 64'(e_v[1]));
      if (e_v[0]) begin
        check({phase, " cpu addr"}, cpu_rsp_addr, e_a[0]);
        check({phase, " cpu hit"}, 64'(cpu_rsp_hit), 64'(e_h[0]));
        check({phase, " cpu dst"}, 64'(cpu_rsp_dst), 64'(e_d[0]));
      end
      if (e_v[1]) begin
        check({phase, " dma addr"}, dma_rsp_addr, e_a[1]);
        check({phase, " dma hit"}, 64'(dma_rsp_hit), 64'(e_h[1]));
        check({phase, " dma dst"}, 64'(dma_rsp_dst), 64'(e_d[1]));
      end
    end
  end

  task automatic wr(input logic [8:0] off, input logic [63:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = off; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [8:0] off, input logic [63:0] exp);
    @(negedge clk);
    cfg_addr = off;
    #1;
    check(tag, cfg_rdata, exp);
    check({tag, " model"}, cfg_rdata, model_read(off));
  endtask

  // Request on one side, check the response against literal values
  task automatic xchk(input string tag, input int side, input logic [63:0] a,
                      input bit hit, input bit dst, input logic [63:0] xa);
    @(negedge clk);
    if (side == 0) begin cpu_req_valid = 1'b1; cpu_req_addr = a; end
    else           begin dma_req_valid = 1'b1; dma_req_addr = a; end
    @(negedge clk);
    #1;
    if (side == 0) begin
      check({tag, " hit"}, 64'(cpu_rsp_hit), 64'(hit));
      check({tag, " dst"}, 64'(cpu_rsp_dst), 64'(dst));
      check({tag, " addr"}, cpu_rsp_addr, xa);
      cpu_req_valid = 1'b0;
    end else begin
      check({tag, " hit"}, 64'(dma_rsp_hit), 64'(hit));
      check({tag, " dst"}, 64'(dma_rsp_dst), 64'(dst));
      check({tag, " addr"}, dma_rsp_addr, xa);
      dma_req_valid = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rsp_valid in reset", 64'(cpu_rsp_valid), 64'h0);
    cfg_addr = 9'h008; #1;
    check("R1 boot base win1", cfg_rdata, 64'h1000_0000);
    @(negedge clk); rst_n = 1'b1;

    phase = "R1";
    xchk("R1 boot ddr", 0, 64'h0123_4567, 1, 0, 64'h0123_4567);
    xchk("R1 boot pci", 0, 64'h1ABC_0000, 1, 1, 64'h1ABC_0000);
    xchk("R1 dma closed", 1, 64'h0000_0040, 0, 0, 64'h0000_0040);
    phase = "R8";
    xchk("R8 miss", 0, 64'h2000_0000, 0, 0, 64'h2000_0000);

    // R9: base and mask alone do not open a window
    phase = "R9";
    wr(9'h010, 64'h4000_0000);
    wr(9'h030, 64'hFFFF_FFFF_C000_0000);
    xchk("R9 closed before remap", 0, 64'h4000_1234, 0, 0, 64'h4000_1234);
    wr(9'h050, 64'h0000_0001_4000_0001);
    phase = "R5";
    xchk("R5 R6 translate", 0, 64'h4000_1234, 1, 1, 64'h0000_0001_4000_1234);
    // R2: readback
    phase = "R2";
    rd("R2 base rd", 9'h010, 64'h4000_0000);
    rd("R2 mask rd", 9'h030, 64'hFFFF_FFFF_C000_0000);
    rd("R2 remap rd", 9'h050, 64'h0000_0001_4000_0001);

    // R7: overlapping window 3 covering [0, 512M)
    phase = "R7";
    wr(9'h018, 64'h0);
    wr(9'h038, 64'hFFFF_FFFF_E000_0000);
    wr(9'h058, 64'h8000_0000);
    xchk("R7 win0 beats win3", 0, 64'h0800_0000, 1, 0, 64'h0800_0000);
    xchk("R7 win1 beats win3", 0, 64'h1800_0000, 1, 1, 64'h1800_0000);
    wr(9'h000, 64'h7000_0000);
    phase = "R4";
    xchk("R4 R7 only win3", 0, 64'h0800_0000, 1, 0, 64'h8800_0000);

    // R11: DMA window 0
    phase = "R11";
    wr(9'h060, 64'h0);
    wr(9'h080, 64'hFFFF_FFFF_C000_0000);
    wr(9'h0A0, 64'h0000_0002_0000_0001);
    xchk("R11 dma lio", 1, 64'h3000_0010, 1, 1, 64'h0000_0002_3000_0010);
    xchk("R11 cpu unaffected", 0, 64'h3000_0010, 0, 0, 64'h3000_0010);

    // R3: holes
    phase = "R3";
    wr(9'h0C0, 64'hDEAD_BEEF_0000_0001);
    wr(9'h178, 64'h1234);
    rd("R3 hole rd", 9'h0C0, 64'h0);
    rd("R3 top hole rd", 9'h178, 64'h0);
    rd("R3 base intact", 9'h000, 64'h7000_0000);
    xchk("R3 translation intact", 0, 64'h0800_0000, 1, 0, 64'h8800_0000);

    // R10: write and request on the same edge
    phase = "R10";
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 9'h040; cfg_wdata = 64'h9000_0000;
    cpu_req_valid = 1'b1; cpu_req_addr = 64'h7000_0100;
    @(negedge clk); #1;
    cfg_wr = 1'b0;
    check("R10 old remap used", cpu_rsp_addr, 64'h0000_0100);
    @(negedge clk); #1;
    check("R10 new remap next", cpu_rsp_addr, 64'h9000_0100);
    cpu_req_valid = 1'b0;
    @(negedge clk); #1;
    check("R10 valid drops", 64'(cpu_rsp_valid), 64'h0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule